// File: doc/BRIEF.md
# Condition and Fixed-Point Status Unit

This block holds a 32-bit condition register, made of eight 4-bit fields, and the three status flags of the fixed-point exception word: summary overflow, overflow and carry. It serves an execution pipeline. The pipeline sends compare requests, single condition-bit writes, overflow and carry updates, and floating-point status loads. Every update is applied on the rising clock edge.

A compare takes two 64-bit operands. It is signed or unsigned, and it looks at 32 or 64 bits. It writes a one-hot less/greater/equal code into a selected field, together with a copy of the sticky summary-overflow flag. A carry helper detects unsigned carry out of a two- or three-operand add and records it in the carry flag. Full-register write ports can overwrite the condition register and the status word, and both registers can be read back.

Top module: `cond_status_unit`

## Requirements
- R1: Field k (0..7) occupies condition-register bits [31-4k : 28-4k], so field 0 is the top nibble. Inside a field, less-than is 0x8, greater-than is 0x4, equal is 0x2 and summary overflow is 0x1.
- R2: A compare replaces its whole target field. The result holds exactly one of less-than, greater-than or equal, plus the summary-overflow flag as it stood before that clock edge.
- R3: With `cmp_wide`=0, only bits [31:0] of each operand are compared, as signed or unsigned according to `cmp_signed`. The upper bits have no effect on the result.
- R4: With `cmp_wide`=1, the full 64-bit operands are compared, as signed or unsigned according to `cmp_signed`.
- R5: A bit write with flat index n sets or clears condition-register bit 31-n. That is mask 0x8 >> (n mod 4) in field n/4. All other bits keep their values.
- R6: A field-1 load writes field 1 as {exception summary, enabled summary, invalid summary, overflow}. These four bits go to less-than, greater-than, equal and summary overflow, in that order.
- R7: An overflow update sets the overflow flag to the given value and ORs that value into summary overflow. A 0 therefore leaves summary overflow set.
- R8: The status word reads summary overflow at bit 31, overflow at bit 30 and carry at bit 29, and zero elsewhere. A status write loads those three bits from the same positions.
- R9: A carry update sets the carry flag when a+b overflows 64 bits. In three-operand mode it also sets the flag when adding c to the truncated sum overflows.
- R10: A condition-register write in a cycle overrides any compare, bit write or field-1 load issued in that cycle. A status write overrides overflow and carry updates in that cycle.
- R11: Updates in one cycle that hit different fields all take effect. On the same field, a compare wins over a field-1 load, and a field-1 load wins over a bit write.
- R12: Synchronous active-high reset clears both registers to zero. Every other update becomes visible on the read ports one clock after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_wr_valid | input | 1 | Write the whole condition register |
| cr_wr_data | input | 32 | Condition-register write value |
| xer_wr_valid | input | 1 | Write the status word |
| xer_wr_data | input | 32 | Status write value (bits 31:29 used) |
| cmp_valid | input | 1 | Compare request |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| cmp_field | input | 3 | Target field of the compare |
| cmp_signed | input | 1 | 1 = signed compare |
| cmp_wide | input | 1 | 1 = 64-bit compare, 0 = low 32 bits |
| bit_valid | input | 1 | Single condition-bit write |
| bit_idx | input | 5 | Flat condition-bit index |
| bit_val | input | 1 | Value for that bit |
| fp_valid | input | 1 | Load field 1 from floating-point status |
| fp_sum | input | 1 | Floating-point exception summary |
| fp_enabled | input | 1 | Enabled-exception summary |
| fp_invalid | input | 1 | Invalid-operation summary |
| fp_overflow | input | 1 | Floating-point overflow |
| ov_valid | input | 1 | Overflow update |
| ov_val | input | 1 | Overflow value |
| carry_valid | input | 1 | Carry update |
| add_a | input | 64 | Carry helper operand a |
| add_b | input | 64 | Carry helper operand b |
| add_c | input | 64 | Carry helper operand c |
| add_three | input | 1 | 1 = include operand c |
| cr_rd | output | 32 | Condition register |
| xer_rd | output | 32 | Status word |

## Verification
The assertions take three things for granted. Reset is held for the first cycles, so the checker's registered copy of the compare field is known before any property is evaluated. The properties on compare results and on the sticky flag also assume that no full-register write lands in the same cycle; they exclude that case in their antecedents and do not forbid it. The stimulus still drives same-cycle write and update collisions on purpose, to show the priority order, and the excluded properties stay silent in those cycles.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int FW       = 4;
  localparam int FP_FIELD = 1;
  localparam int XW       = 32;
  localparam int SO_POS   = 31;
  localparam int OV_POS   = 30;
  localparam int CA_POS   = 29;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;
endpackage

// File: rtl/csu_compare.sv
module csu_compare #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sgn,
  input  logic          wide,
  output logic          lt,
  output logic          gt,
  output logic          eq
);
  localparam int HW = DW / 2;
  localparam int EW = DW + 1;

  logic [EW-1:0] ea, eb;

  // Extend each operand one bit so one signed compare covers every mode.
  always_comb begin
    if (wide) begin
      ea = {sgn & a[DW-1], a};
      eb = {sgn & b[DW-1], b};
    end else begin
      ea = {{(EW-HW){sgn & a[HW-1]}}, a[HW-1:0]};
      eb = {{(EW-HW){sgn & b[HW-1]}}, b[HW-1:0]};
    end
  end

  assign lt = $signed(ea) < $signed(eb);
  assign gt = $signed(ea) > $signed(eb);
  assign eq = (ea == eb);
endmodule

// File: rtl/csu_carry.sv
module csu_carry #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic          three,
  output logic          carry
);
  logic [DW-1:0] s1, s2;
  logic          c1, c2;

  assign s1    = a + b;
  assign c1    = s1 < a;
  assign s2    = s1 + c;
  assign c2    = s2 < s1;
  assign carry = c1 | (three & c2);
endmodule

// File: rtl/csu_cr_merge.sv
module csu_cr_merge
  import csu_pkg::*;
#(
  parameter int NF = 8
) (
  input  logic [NF*FW-1:0]       cr_q,
  input  logic                   wr_hit,
  input  logic [NF*FW-1:0]       wr_data,
  input  logic                   cmp_hit,
  input  logic [$clog2(NF)-1:0]  cmp_field,
  input  logic [FW-1:0]          cmp_nib,
  input  logic                   fp_hit,
  input  logic [FW-1:0]          fp_nib,
  input  logic                   bit_hit,
  input  logic [$clog2(NF)+1:0]  bit_idx,
  input  logic                   bit_val,
  output logic [NF*FW-1:0]       cr_d
);
  localparam int CRW = NF * FW;
  localparam int FSW = $clog2(NF);
  localparam int BW  = FSW + 2;

  logic [FW-1:0] nib_d [NF];

  for (genvar k = 0; k < NF; k++) begin : g_fld
    localparam int HI = CRW - 1 - k * FW;
    always_comb begin
      logic [FW-1:0] n;
      n = cr_q[HI -: FW];
      if (bit_hit && bit_idx[BW-1:2] == FSW'(k))
        n[2'd3 - bit_idx[1:0]] = bit_val;
      if (k == FP_FIELD && fp_hit)
        n = fp_nib;
      if (cmp_hit && cmp_field == FSW'(k))
        n = cmp_nib;
      if (wr_hit)
        n = wr_data[HI -: FW];
      nib_d[k] = n;
    end
    assign cr_d[HI -: FW] = nib_d[k];
  end
endmodule

// File: rtl/cond_status_unit.sv
module cond_status_unit
  import csu_pkg::*;
#(
  parameter int DW = 64,
  parameter int NF = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cr_wr_valid,
  input  logic [NF*4-1:0]       cr_wr_data,
  input  logic                  xer_wr_valid,
  input  logic [31:0]           xer_wr_data,
  input  logic                  cmp_valid,
  input  logic [DW-1:0]         cmp_a,
  input  logic [DW-1:0]         cmp_b,
  input  logic [$clog2(NF)-1:0] cmp_field,
  input  logic                  cmp_signed,
  input  logic                  cmp_wide,
  input  logic                  bit_valid,
  input  logic [$clog2(NF)+1:0] bit_idx,
  input  logic                  bit_val,
  input  logic                  fp_valid,
  input  logic                  fp_sum,
  input  logic                  fp_enabled,
  input  logic                  fp_invalid,
  input  logic                  fp_overflow,
  input  logic                  ov_valid,
  input  logic                  ov_val,
  input  logic                  carry_valid,
  input  logic [DW-1:0]         add_a,
  input  logic [DW-1:0]         add_b,
  input  logic [DW-1:0]         add_c,
  input  logic                  add_three,
  output logic [NF*4-1:0]       cr_rd,
  output logic [31:0]           xer_rd
);
  localparam int CRW = NF * FW;

  logic [CRW-1:0] cr_q, cr_d;
  logic           so_q, ov_q, ca_q;
  logic           c_lt, c_gt, c_eq, carry;
  crf_t           cmp_nib, fp_nib;

  csu_compare #(.DW(DW)) u_cmp (
    .a(cmp_a), .b(cmp_b), .sgn(cmp_signed), .wide(cmp_wide),
    .lt(c_lt), .gt(c_gt), .eq(c_eq)
  );

  csu_carry #(.DW(DW)) u_carry (
    .a(add_a), .b(add_b), .c(add_c), .three(add_three), .carry(carry)
  );

  assign cmp_nib = '{lt: c_lt, gt: c_gt, eq: c_eq, so: so_q};
  assign fp_nib  = '{lt: fp_sum, gt: fp_enabled, eq: fp_invalid, so: fp_overflow};

  csu_cr_merge #(.NF(NF)) u_merge (
    .cr_q(cr_q), .wr_hit(cr_wr_valid), .wr_data(cr_wr_data),
    .cmp_hit(cmp_valid), .cmp_field(cmp_field), .cmp_nib(cmp_nib),
    .fp_hit(fp_valid), .fp_nib(fp_nib),
    .bit_hit(bit_valid), .bit_idx(bit_idx), .bit_val(bit_val),
    .cr_d(cr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else     cr_q <= cr_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q <= 1'b0;
      ov_q <= 1'b0;
      ca_q <= 1'b0;
    end else if (xer_wr_valid) begin
      so_q <= xer_wr_data[SO_POS];
      ov_q <= xer_wr_data[OV_POS];
      ca_q <= xer_wr_data[CA_POS];
    end else begin
      if (ov_valid) begin
        ov_q <= ov_val;
        so_q <= so_q | ov_val;
      end
      if (carry_valid) ca_q <= carry;
    end
  end

  assign cr_rd  = cr_q;
  assign xer_rd = {so_q, ov_q, ca_q, {(XW-3){1'b0}}};
endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
  parameter int NF = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cr_wr_valid,
  input logic [NF*4-1:0]       cr_wr_data,
  input logic                  xer_wr_valid,
  input logic                  cmp_valid,
  input logic [$clog2(NF)-1:0] cmp_field,
  input logic                  ov_valid,
  input logic                  ov_val,
  input logic [NF*4-1:0]       cr_rd,
  input logic [31:0]           xer_rd
);
  localparam int CRW = NF * 4;

  logic [$clog2(NF)-1:0] fld_q;
  logic [3:0]            nib;

  always_ff @(posedge clk) fld_q <= cmp_field;
  assign nib = cr_rd[CRW-1-4*int'(fld_q) -: 4];

  // R2: one-hot compare code in the target field
  p_onehot_code_r2: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cr_wr_valid) |=> ($countones(nib[3:1]) == 1));

  // R2: summary-overflow copy from the previous cycle's flag
  p_so_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cr_wr_valid) |=> (nib[0] == $past(xer_rd[31])));

  // R7: summary overflow is sticky without a status write
  p_sticky_so_r7: assert property (@(posedge clk) disable iff (rst)
    (xer_rd[31] && !xer_wr_valid) |=> xer_rd[31]);

  // R7: overflow flag follows the update value
  p_ov_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (ov_valid && !xer_wr_valid) |=> (xer_rd[30] == $past(ov_val)));

  // R10: full write lands regardless of other updates
  p_cr_write_r10: assert property (@(posedge clk) disable iff (rst)
    cr_wr_valid |=> (cr_rd == $past(cr_wr_data)));
endmodule

bind cond_status_unit csu_checker #(.NF(NF)) u_chk (
  .clk(clk), .rst(rst), .cr_wr_valid(cr_wr_valid), .cr_wr_data(cr_wr_data),
  .xer_wr_valid(xer_wr_valid), .cmp_valid(cmp_valid), .cmp_field(cmp_field),
  .ov_valid(ov_valid), .ov_val(ov_val), .cr_rd(cr_rd), .xer_rd(xer_rd)
);

// File: tb/cond_status_unit_bench.sv
`timescale 1ns/1ps
module cond_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cr_wr_valid, xer_wr_valid, cmp_valid, cmp_signed, cmp_wide;
  logic [31:0] cr_wr_data, xer_wr_data;
  logic [63:0] cmp_a, cmp_b, add_a, add_b, add_c;
  logic [2:0]  cmp_field;
  logic        bit_valid, bit_val, fp_valid, fp_sum, fp_enabled, fp_invalid, fp_overflow;
  logic [4:0]  bit_idx;
  logic        ov_valid, ov_val, carry_valid, add_three;
  logic [31:0] cr_rd, xer_rd;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cond_status_unit u_cond_status_unit (.*);

  // {a, b, field, signed, wide, expected {lt,gt,eq}}
  localparam logic [135:0] VEC [10] = '{
    {64'h5, 64'h7, 3'd0, 1'b0, 1'b1, 3'b100},                                   // R4 unsigned
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'd2, 1'b1, 1'b1, 3'b100},                 // R4 signed
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'd3, 1'b0, 1'b1, 3'b010},                 // R4 unsigned
    {64'h1_0000_0000, 64'h5, 3'd4, 1'b0, 1'b0, 3'b100},                         // R3 upper ignored
    {64'hFFFF_0000_8000_0000, 64'h0000_0001_0000_0001, 3'd5, 1'b1, 1'b0, 3'b100}, // R3 signed
    {64'hFFFF_0000_8000_0000, 64'h0000_0001_0000_0001, 3'd6, 1'b0, 1'b0, 3'b010}, // R3 unsigned
    {64'hAAAA_0000_DEAD_BEEF, 64'h5555_0000_DEAD_BEEF, 3'd7, 1'b0, 1'b0, 3'b001}, // R3 equal low
    {64'hAAAA_0000_DEAD_BEEF, 64'h5555_0000_DEAD_BEEF, 3'd1, 1'b0, 1'b1, 3'b010}, // R4
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'd0, 1'b1, 1'b1, 3'b001}, // R4 equal
    {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 3'd3, 1'b1, 1'b1, 3'b100}  // R4 min<max
  };

  task automatic idle();
    cr_wr_valid = 0; cr_wr_data = '0; xer_wr_valid = 0; xer_wr_data = '0;
    cmp_valid = 0; cmp_a = '0; cmp_b = '0; cmp_field = '0; cmp_signed = 0; cmp_wide = 0;
    bit_valid = 0; bit_idx = '0; bit_val = 0;
    fp_valid = 0; fp_sum = 0; fp_enabled = 0; fp_invalid = 0; fp_overflow = 0;
    ov_valid = 0; ov_val = 0; carry_valid = 0; add_a = '0; add_b = '0; add_c = '0; add_three = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic carry_op(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic three);
    idle(); carry_valid = 1; add_a = a; add_b = b; add_c = c; add_three = three;
    tick();
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    chk("R12 reset cr", cr_rd, 32'h0);
    chk("R12 reset xer", xer_rd, 32'h0);

    // Table walk: compare results per field (R1, R3, R4), SO clear
    for (int i = 0; i < 10; i++) begin
      idle();
      cmp_valid = 1; cmp_a = VEC[i][135:72]; cmp_b = VEC[i][71:8];
      cmp_field = VEC[i][7:5]; cmp_signed = VEC[i][4]; cmp_wide = VEC[i][3];
      tick();
      chk($sformatf("R1 R3 R4 vec%0d", i),
          32'((cr_rd >> (28 - 4 * int'(VEC[i][7:5]))) & 32'hF),
          {28'h0, VEC[i][2:0], 1'b0});
    end

    // R10 CR write wins over compare on the same cycle
    idle(); cr_wr_valid = 1; cr_wr_data = 32'h0;
    cmp_valid = 1; cmp_a = 64'd1; cmp_b = 64'd2; cmp_field = 3'd0; cmp_wide = 1;
    tick();
    chk("R10 cr write over compare", cr_rd, 32'h0);

    // R5 flat bit set/clear
    idle(); bit_valid = 1; bit_idx = 5'd6; bit_val = 1; tick();
    chk("R5 set bit 6", cr_rd, 32'h0200_0000);
    idle(); bit_valid = 1; bit_idx = 5'd31; bit_val = 1; tick();
    chk("R5 set bit 31", cr_rd, 32'h0200_0001);
    idle(); bit_valid = 1; bit_idx = 5'd6; bit_val = 0; tick();
    chk("R5 clear bit 6", cr_rd, 32'h0000_0001);

    // R6 field-1 load
    idle(); fp_valid = 1; fp_sum = 1; fp_enabled = 0; fp_invalid = 1; fp_overflow = 1; tick();
    chk("R6 field1 load", cr_rd, 32'h0B00_0001);

    // R7 overflow and sticky summary
    idle(); ov_valid = 1; ov_val = 1; tick();
    chk("R7 ov set", xer_rd, 32'hC000_0000);
    idle(); ov_valid = 1; ov_val = 0; tick();
    chk("R7 so sticky", xer_rd, 32'h8000_0000);

    // R2 compare copies SO
    idle(); cmp_valid = 1; cmp_a = 64'd1; cmp_b = 64'd1; cmp_field = 3'd2; cmp_wide = 1; tick();
    chk("R2 so copy", cr_rd, 32'h0B30_0001);

    // R8 status layout
    idle(); xer_wr_valid = 1; xer_wr_data = 32'h2FFF_FFFF; tick();
    chk("R8 status write", xer_rd, 32'h2000_0000);

    // R9 carry helper
    carry_op(64'd1, 64'd2, 64'd0, 1'b0);
    chk("R9 no carry", xer_rd, 32'h0);
    carry_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0);
    chk("R9 two-input carry", xer_rd, 32'h2000_0000);
    carry_op(64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'd1, 1'b0);
    chk("R9 c unused", xer_rd, 32'h0);
    carry_op(64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'd1, 1'b1);
    chk("R9 three-input carry", xer_rd, 32'h2000_0000);

    // R10 status write over overflow
    idle(); xer_wr_valid = 1; xer_wr_data = 32'h0; ov_valid = 1; ov_val = 1; tick();
    chk("R10 status write over ov", xer_rd, 32'h0);

    // R11 merge priority
    idle(); cr_wr_valid = 1; cr_wr_data = 32'h1234_5678; tick();
    chk("R10 cr readback", cr_rd, 32'h1234_5678);
    idle(); cmp_valid = 1; cmp_a = 64'd2; cmp_b = 64'd1; cmp_field = 3'd1; cmp_wide = 1;
    fp_valid = 1; fp_sum = 1; fp_enabled = 1; fp_invalid = 1; fp_overflow = 1;
    bit_valid = 1; bit_idx = 5'd4; bit_val = 1; tick();
    chk("R11 compare wins", cr_rd, 32'h1434_5678);
    idle(); fp_valid = 1; fp_sum = 1; fp_overflow = 1;
    bit_valid = 1; bit_idx = 5'd4; bit_val = 0; tick();
    chk("R11 field1 over bit", cr_rd, 32'h1934_5678);
    idle(); fp_valid = 1; bit_valid = 1; bit_idx = 5'd0; bit_val = 1; tick();
    chk("R11 different fields", cr_rd, 32'h9034_5678);

    // R12 reset clears again
    idle(); xer_wr_valid = 1; xer_wr_data = 32'hE000_0000; tick();
    idle(); rst = 1; tick(); rst = 0;
    chk("R12 reset cr again", cr_rd, 32'h0);
    chk("R12 reset xer again", xer_rd, 32'h0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule